// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches two 8-bit input ports for level changes and raises an interrupt request when a change of interest occurs. Each pin can be set to react to its low-to-high transition, its high-to-low transition, or both. The two directions are chosen with two separate mask registers. When a selected transition is seen, a sticky per-pin flag is latched. Every latched flag feeds one summary bit.

Software reaches the block through a small synchronous register bus. It sets the masks and the master interrupt switch, reads the flags, and clears flags by writing zeros. Turning the master switch off silences only the interrupt output. Detection and flag capture carry on as before. While the core is asleep, the same condition also drives a wake request.

Pins are asynchronous to the block clock, so they pass through a synchronizer before edge detection.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, all mask registers, all flags and the master enable read as zero, and `irq_o` and `wake_o` are low. Pins already high during reset produce no flag once the rising masks are enabled afterwards.
- R2: A pin whose bit is set in its port's rising mask sets its flag on a 0-to-1 transition. A 1-to-0 transition on that pin, with its falling mask bit clear, leaves the flag clear. Any combination of pins may be enabled at once.
- R3: A pin whose bit is set in its port's falling mask sets its flag on a 1-to-0 transition.
- R4: A pin with both mask bits set flags both the 0-to-1 and the 1-to-0 transition.
- R5: Transitions on pins with both mask bits clear never set a flag.
- R6: A set flag stays set until software writes 0 to that bit. Writing 1 to it keeps it set.
- R7: Writing 1 to a clear flag bit leaves it clear. Only detection can set a flag.
- R8: When a detected transition and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: The summary bit (bit 1 of the control register) is the OR of all 16 flags across both ports.
- R10: `irq_o` is high exactly when the master enable (bit 0 of the control register) is set and the summary bit is set. With the master enable clear, flags are still captured.
- R11: `wake_o` is high exactly when `sleep_i` is high and `irq_o` is high. The flag register already shows the flag when `wake_o` rises.
- R12: The register map is as follows:
  - address 0: rising mask for port A
  - address 1: rising mask for port B
  - address 2: falling mask for port A
  - address 3: falling mask for port B
  - address 4: flags for port A
  - address 5: flags for port B
  - address 6: control register
  - address 7: reads zero

  Bit n of each mask or flag register is pin n. The summary bit ignores writes. Reads are combinational while `bus_sel_i` is high.
- R13: A flag first reads set after the third rising clock edge following the pin change (two synchronizer stages plus the flag register), and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_a_i | input | 8 | Port A pin levels (asynchronous) |
| pins_b_i | input | 8 | Port B pin levels (asynchronous) |
| sleep_i | input | 1 | High while the core is asleep |
| bus_sel_i | input | 1 | Register bus access select |
| bus_we_i | input | 1 | Write strobe, qualified by `bus_sel_i` |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, zero when not selected |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request for a sleeping core |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- a flag is never set without a detected transition;
- a flag only drops on a clearing write;
- a detection always lands in its flag even against a clear;
- no flag appears in the priming cycle after reset;
- the interrupt stays low with the master enable off;
- `wake_o` implies both `sleep_i` and `irq_o`.

The directed scenarios show what needs pin stimulus and readback:
- which mask bit selects which direction;
- the three-edge latency;
- the register map and read-only summary bit;
- quiet pins after a reset with pins high;
- the exact cycle in which a transition collides with a software clear.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_RISE_A = 3'd0,
    RA_RISE_B = 3'd1,
    RA_FALL_A = 3'd2,
    RA_FALL_B = 3'd3,
    RA_FLAG_A = 3'd4,
    RA_FLAG_B = 3'd5,
    RA_CTRL   = 3'd6,
    RA_NONE   = 3'd7
  } pci_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SUM_BIT = 1;
endpackage

// File: rtl/pci_rst_sync.sv
module pci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[1];
endmodule

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  // Synchronizer flops carry no reset; they settle while reset is held.
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= din_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/pci_edge_bank.sv
module pci_edge_bank #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] smp_i,
  input  logic [NPIN-1:0] rise_en_i,
  input  logic [NPIN-1:0] fall_en_i,
  input  logic [NPIN-1:0] clr_mask_i,
  output logic [NPIN-1:0] hit_o,
  output logic [NPIN-1:0] flags_o
);
  logic            armed_q;
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] prev_d;
  logic [NPIN-1:0] flags_q;
  logic [NPIN-1:0] flags_d;
  logic [NPIN-1:0] hit;

  // Per-pin edge comparison against the previous synchronized sample.
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic went_up;
    logic went_down;
    assign went_up   = smp_i[p] & ~prev_q[p];
    assign went_down = ~smp_i[p] & prev_q[p];
    assign hit[p]    = armed_q & ((went_up & rise_en_i[p]) |
                                  (went_down & fall_en_i[p]));
  end

  // Next state: detection has priority over a software clear.
  always_comb begin
    prev_d  = smp_i;
    flags_d = (flags_q & ~clr_mask_i) | hit;
  end

  // The first cycle after reset only primes prev_q from the live samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= prev_d;
      flags_q <= flags_d;
    end
  end

  assign hit_o   = hit;
  assign flags_o = flags_q;

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask_i)) == $past(flags_q & ~clr_mask_i)));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(hit)) == $past(hit)));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0));

  // R1
  prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> (flags_q == '0));
endmodule

// File: rtl/pci_regs.sv
module pci_regs
  import pci_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [PORT_W-1:0]   bus_wdata_i,
  output logic [PORT_W-1:0]   bus_rdata_o,
  input  logic [2*PORT_W-1:0] flags_i,
  output logic [2*PORT_W-1:0] rise_en_o,
  output logic [2*PORT_W-1:0] fall_en_o,
  output logic [2*PORT_W-1:0] clr_mask_o,
  output logic                master_en_o,
  output logic                summary_o
);
  localparam int unsigned NPIN = 2 * PORT_W;

  logic [NPIN-1:0] rise_q, rise_d;
  logic [NPIN-1:0] fall_q, fall_d;
  logic            en_q, en_d;
  logic            wr;
  logic            summary;

  assign wr      = bus_sel_i & bus_we_i;
  assign summary = |flags_i;

  // Next-state for the configuration registers.
  always_comb begin
    rise_d = rise_q;
    fall_d = fall_q;
    en_d   = en_q;
    if (wr) begin
      unique case (bus_addr_i)
        RA_RISE_A: rise_d[PORT_W-1:0]    = bus_wdata_i;
        RA_RISE_B: rise_d[NPIN-1:PORT_W] = bus_wdata_i;
        RA_FALL_A: fall_d[PORT_W-1:0]    = bus_wdata_i;
        RA_FALL_B: fall_d[NPIN-1:PORT_W] = bus_wdata_i;
        RA_CTRL:   en_d                  = bus_wdata_i[CTRL_EN_BIT];
        default:   ;
      endcase
    end
  end

  // Clearing writes: a zero bit in the write data clears that flag.
  always_comb begin
    clr_mask_o = '0;
    if (wr && (bus_addr_i == RA_FLAG_A)) begin
      clr_mask_o[PORT_W-1:0] = ~bus_wdata_i;
    end
    if (wr && (bus_addr_i == RA_FLAG_B)) begin
      clr_mask_o[NPIN-1:PORT_W] = ~bus_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= 1'b0;
    end else if (wr) begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      en_q   <= en_d;
    end
  end

  // Combinational read mux.
  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      unique case (bus_addr_i)
        RA_RISE_A: bus_rdata_o = rise_q[PORT_W-1:0];
        RA_RISE_B: bus_rdata_o = rise_q[NPIN-1:PORT_W];
        RA_FALL_A: bus_rdata_o = fall_q[PORT_W-1:0];
        RA_FALL_B: bus_rdata_o = fall_q[NPIN-1:PORT_W];
        RA_FLAG_A: bus_rdata_o = flags_i[PORT_W-1:0];
        RA_FLAG_B: bus_rdata_o = flags_i[NPIN-1:PORT_W];
        RA_CTRL: begin
          bus_rdata_o[CTRL_EN_BIT]  = en_q;
          bus_rdata_o[CTRL_SUM_BIT] = summary;
        end
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign rise_en_o   = rise_q;
  assign fall_en_o   = fall_q;
  assign master_en_o = en_q;
  assign summary_o   = summary;

  // R12
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(rise_q) && $stable(fall_q) && $stable(en_q)));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pci_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins_a_i,
  input  logic [PORT_W-1:0] pins_b_i,
  input  logic              sleep_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [PORT_W-1:0] bus_wdata_i,
  output logic [PORT_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned NPIN = 2 * PORT_W;

  logic            rst_sync_n;
  logic [NPIN-1:0] smp;
  logic [NPIN-1:0] rise_en;
  logic [NPIN-1:0] fall_en;
  logic [NPIN-1:0] clr_mask;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] flags;
  logic            master_en;
  logic            summary;

  pci_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pci_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .din_i  ({pins_b_i, pins_a_i}),
    .dout_o (smp)
  );

  pci_edge_bank #(.NPIN(NPIN)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .smp_i      (smp),
    .rise_en_i  (rise_en),
    .fall_en_i  (fall_en),
    .clr_mask_i (clr_mask),
    .hit_o      (hit),
    .flags_o    (flags)
  );

  pci_regs #(.PORT_W(PORT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .flags_i     (flags),
    .rise_en_o   (rise_en),
    .fall_en_o   (fall_en),
    .clr_mask_o  (clr_mask),
    .master_en_o (master_en),
    .summary_o   (summary)
  );

  assign irq_o  = master_en & summary;
  assign wake_o = sleep_i & irq_o;

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!master_en && (hit != '0)) |=> !irq_o);

  // R11
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_o |-> (irq_o && sleep_i && (flags != '0)));
endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pa, pb;
  logic       sleep;
  logic       sel, we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, wake;

  int total = 0;
  int bad   = 0;

  localparam logic [2:0] A_RA = 3'd0, A_RB = 3'd1, A_FA = 3'd2, A_FB = 3'd3;
  localparam logic [2:0] A_GA = 3'd4, A_GB = 3'd5, A_CT = 3'd6, A_NO = 3'd7;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins_a_i(pa), .pins_b_i(pb), .sleep_i(sleep),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) tick();
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick();
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 8'h00);
    chk("R1 irq low", {7'b0, irq}, 8'h00);
    chk("R1 wake low", {7'b0, wake}, 8'h00);
    wr(A_RA, 8'hFF);
    settle();
    rd_chk("R1 no flag from pins high in reset", A_GA, 8'h00);
    wr(A_RA, 8'h00);
    pa = 8'h00;
    settle();
  endtask

  task automatic t_regmap();
    wr(A_RA, 8'hA5); wr(A_RB, 8'h3C); wr(A_FA, 8'h0F); wr(A_FB, 8'h81);
    rd_chk("R12 rise A", A_RA, 8'hA5);
    rd_chk("R12 rise B", A_RB, 8'h3C);
    rd_chk("R12 fall A", A_FA, 8'h0F);
    rd_chk("R12 fall B", A_FB, 8'h81);
    wr(A_CT, 8'h03);
    rd_chk("R12 summary read-only", A_CT, 8'h01);
    rd_chk("R12 unused addr", A_NO, 8'h00);
    wr(A_RA, 0); wr(A_RB, 0); wr(A_FA, 0); wr(A_FB, 0); wr(A_CT, 0);
  endtask

  task automatic t_rise();
    wr(A_RA, 8'h01);
    pa = 8'h01;
    tick(); tick();
    rd_chk("R13 not yet after two edges", A_GA, 8'h00);
    tick();
    rd_chk("R13/R2 flag after third edge", A_GA, 8'h01);
    wr(A_GA, 8'h00);
    pa = 8'h00;
    settle(); tick();
    rd_chk("R2 falling ignored without fall mask", A_GA, 8'h00);
    wr(A_RA, 8'hFF);
    pa = 8'h5A;
    settle();
    rd_chk("R2 pin combination", A_GA, 8'h5A);
    wr(A_GA, 8'h00);
    wr(A_RA, 8'h00);
    pa = 8'h00;
    settle();
    rd_chk("R2 cleanup", A_GA, 8'h00);
  endtask

  task automatic t_fall();
    wr(A_FB, 8'h80);
    pb = 8'h80;
    settle();
    rd_chk("R3 rising not flagged", A_GB, 8'h00);
    pb = 8'h00;
    settle();
    rd_chk("R3 falling flagged", A_GB, 8'h80);
    wr(A_GB, 8'h00);
    wr(A_FB, 8'h00);
  endtask

  task automatic t_both();
    wr(A_RA, 8'h08); wr(A_FA, 8'h08);
    pa = 8'h08;
    settle();
    rd_chk("R4 rise with both", A_GA, 8'h08);
    wr(A_GA, 8'h00);
    pa = 8'h00;
    settle();
    rd_chk("R4 fall with both", A_GA, 8'h08);
    wr(A_GA, 8'h00);
    wr(A_RA, 8'h00); wr(A_FA, 8'h00);
  endtask

  task automatic t_disabled();
    pa = 8'hFF; pb = 8'hFF;
    settle();
    pa = 8'h00; pb = 8'h00;
    settle();
    rd_chk("R5 port A quiet", A_GA, 8'h00);
    rd_chk("R5 port B quiet", A_GB, 8'h00);
  endtask

  task automatic t_sticky();
    wr(A_RA, 8'h08);
    pa = 8'h08;
    settle();
    pa = 8'h00;
    settle();
    rd_chk("R6 flag sticky", A_GA, 8'h08);
    wr(A_GA, 8'hFF);
    rd_chk("R6/R7 write ones keeps and adds none", A_GA, 8'h08);
    rd_chk("R9 summary set", A_CT, 8'h02);
    wr(A_GA, 8'h00);
    rd_chk("R6 cleared by zero", A_GA, 8'h00);
    rd_chk("R9 summary clear", A_CT, 8'h00);
    wr(A_RA, 8'h00);
  endtask

  task automatic t_collision();
    wr(A_RA, 8'h06); wr(A_FA, 8'h02);
    pa = 8'h06;
    settle();
    rd_chk("R8 setup", A_GA, 8'h06);
    pa = 8'h04;
    tick(); tick();
    wr(A_GA, 8'h00);
    rd_chk("R8 edge beats clear", A_GA, 8'h02);
    wr(A_GA, 8'h00);
    rd_chk("R8 later clear works", A_GA, 8'h00);
    wr(A_RA, 8'h00); wr(A_FA, 8'h00);
    pa = 8'h00;
    settle();
  endtask

  task automatic t_irq();
    wr(A_RB, 8'h10);
    pb = 8'h10;
    settle();
    rd_chk("R10 flag with master off", A_GB, 8'h10);
    chk("R10 irq off", {7'b0, irq}, 8'h00);
    rd_chk("R9 summary from port B", A_CT, 8'h02);
    sleep = 1'b1;
    #1;
    chk("R11 no wake with master off", {7'b0, wake}, 8'h00);
    wr(A_CT, 8'h01);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    chk("R11 wake while asleep", {7'b0, wake}, 8'h01);
    sleep = 1'b0;
    #1;
    chk("R11 no wake when awake", {7'b0, wake}, 8'h00);
    wr(A_GB, 8'h00);
    chk("R10 irq drops on clear", {7'b0, irq}, 8'h00);
    sleep = 1'b1;
    pb = 8'h00;
    settle();
    chk("R11 no wake on disabled edge", {7'b0, wake}, 8'h00);
    pb = 8'h10;
    settle();
    rd_chk("R11 flag visible with wake", A_GB, 8'h10);
    chk("R11 wake raised by edge", {7'b0, wake}, 8'h01);
    sleep = 1'b0;
    wr(A_GB, 8'h00); wr(A_RB, 8'h00); wr(A_CT, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; pa = 8'hFF; pb = 8'h00; sleep = 1'b0;
    sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_disabled();
    t_sticky();
    t_collision();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule